// File: doc/BRIEF.md
# FIFO Threshold Offset Programming Unit

This block owns the two threshold values that the flag logic of a dual-clock FIFO compares against: the almost-empty offset and the almost-full offset. It decides how those values are set and presents them continuously on two output buses. The block does not hold FIFO data and does not compute flags. It only stores the thresholds and tells the surrounding FIFO which write and read cycles are ordinary data transfers.

The programming method is fixed while master reset is held. The level of the load-select pin picks parallel or serial programming. The low three bits of the data input pick one of eight preset threshold pairs, which the registers take at once. After reset, holding load-select low turns a write cycle into a threshold write and a read cycle into a threshold read-back. Parallel mode takes whole words from the data input. Serial mode shifts one bit per write clock from a dedicated serial input. A partial reset restarts the access sequence but keeps the programmed values.

Top module: `ofs_prog_unit`

## Requirements
- R1: On every write-clock edge with `mst_rst_n` low, the unit latches the programming method from `ld_sel` (0 = parallel, 1 = serial) and a preset index k from `d_in[2:0]`. Both offsets load the preset values: almost-empty = (8 << k) - 1 and almost-full = (16 << k) - 1.
- R2: A write-clock edge with `part_rst_n` low, and no master reset, leaves both offsets unchanged. It returns the parallel write order, the serial bit position and (on a read-clock edge) the read-back order to their starting points.
- R3: In parallel mode, a write-clock edge with `ld_sel` = 0 and `wr_en_n` = 0 stores `d_in` into an offset register. Successive such cycles alternate: almost-empty first, then almost-full.
- R4: In parallel mode, a read-clock edge with `ld_sel` = 0 and `rd_en_n` = 0 puts an offset on `rd_data` and raises `rd_valid` after that edge. Successive reads alternate: almost-empty first, then almost-full. `rd_valid` is low after any read-clock edge without such a request.
- R5: In serial mode, each write-clock edge with `ser_en_n` = 0 stores `ser_din` into the next offset bit. The first DW bits fill the almost-empty offset starting at bit 0. The next DW bits fill the almost-full offset starting at bit 0.
- R6: In serial mode, serial bits that arrive after all 2*DW bits are stored leave both offsets unchanged.
- R7: In serial mode, threshold write cycles (`ld_sel` = 0, `wr_en_n` = 0) leave both offsets unchanged, and threshold read cycles leave `rd_valid` low.
- R8: In parallel mode, `ser_en_n` and `ser_din` have no effect on either offset.
- R9: `fifo_wr` is high exactly when `wr_en_n` = 0, `ld_sel` = 1 and both resets are high. `fifo_rd` is high exactly when `rd_en_n` = 0, `ld_sel` = 1 and both resets are high. A data write cycle does not change the offsets.
- R10: A read-clock edge with either reset low clears `rd_data` to 0 and `rd_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mst_rst_n | input | 1 | Master reset, active low, synchronous to both clocks |
| part_rst_n | input | 1 | Partial reset, active low, synchronous to both clocks |
| ld_sel | input | 1 | Method select during master reset; threshold-access select afterwards (low) |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| ser_en_n | input | 1 | Serial bit enable, active low |
| ser_din | input | 1 | Serial threshold bit |
| d_in | input | DW | Data input bus; preset index in bits 2:0 during master reset |
| rd_data | output | DW | Read-back threshold value |
| rd_valid | output | 1 | High for the cycle after a threshold read |
| ae_off | output | DW | Almost-empty offset to the flag logic |
| af_off | output | DW | Almost-full offset to the flag logic |
| fifo_wr | output | 1 | Write cycle is a FIFO data write |
| fifo_rd | output | 1 | Read cycle is a FIFO data read |

## Verification
The hardest state to reach is the saturated serial stream: all 2*DW bits delivered and further bits arriving, ideally with both registers holding values that differ from the presets. The bench selects serial mode in master reset and shifts two distinct words in bit by bit. It checks the almost-empty register at the midpoint, then keeps shifting ones past the end and confirms both registers hold. A partial reset then restarts the serial sequence, and the bench shows that the next bits land in the almost-empty register again while the almost-full value survives.

// File: rtl/ofs_pkg.sv
// Package: shared types and the preset threshold calculation.
// Assumes offsets are at most 32 bits wide.
package ofs_pkg;

    typedef enum logic {
        PROG_PAR = 1'b0,
        PROG_SER = 1'b1
    } prog_mode_e;

    // Almost-empty preset for index k: (8 << k) - 1.
    function automatic logic [31:0] preset_ae(input logic [2:0] k);
        return (32'd8 << k) - 32'd1;
    endfunction

    // Almost-full preset for index k: (16 << k) - 1.
    function automatic logic [31:0] preset_af(input logic [2:0] k);
        return (32'd16 << k) - 32'd1;
    endfunction

endpackage

// File: rtl/ofs_serial_ctr.sv
// Serial bit position counter. It counts serial bits accepted so far,
// saturates at 2*DW, and gives the bit position within the register that
// is being filled. Assumes clr already combines both resets.
module ofs_serial_ctr #(
    parameter int DW = 18
) (
    input  logic                   clk,
    input  logic                   clr,
    input  logic                   step,
    output logic                   take,
    output logic                   to_af,
    output logic [$clog2(DW)-1:0]  bit_pos
);
    localparam int TOTAL = 2 * DW;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int LW    = $clog2(DW);

    logic [CW-1:0] cnt;

    // Accept a bit only while positions remain.
    assign take  = step && (cnt < CW'(TOTAL));
    assign to_af = (cnt >= CW'(DW));
    // Position inside the current register.
    always_comb begin
        if (to_af) bit_pos = LW'(cnt - CW'(DW));
        else       bit_pos = LW'(cnt);
    end

    // Advance the count on each accepted bit; restart on reset.
    always_ff @(posedge clk) begin
        if (clr)       cnt <= '0;
        else if (take) cnt <= cnt + 1'b1;
    end

    // The counter never passes the end of the stream (R6).
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (clr)
        cnt <= CW'(TOTAL));
    // A saturated counter holds its value (R6).
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (clr)
        (cnt == CW'(TOTAL)) |=> (cnt == CW'(TOTAL)));

endmodule

// File: rtl/ofs_store.sv
// Write-side threshold storage. It latches the programming method and preset
// in master reset, takes parallel words in almost-empty/almost-full order, and
// takes serial bits at positions given by the serial counter.
// Assumes both resets are synchronous to wr_clk and held for at least one edge.
module ofs_store
    import ofs_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          mst_rst_n,
    input  logic          part_rst_n,
    input  logic          ld_sel,
    input  logic          wr_en_n,
    input  logic          ser_en_n,
    input  logic          ser_din,
    input  logic [DW-1:0] d_in,
    output prog_mode_e    mode,
    output logic [DW-1:0] ae_off,
    output logic [DW-1:0] af_off
);
    localparam int LW = $clog2(DW);

    logic          wptr;       // 0: almost-empty next, 1: almost-full next
    logic          had_mrst;   // master reset seen at least once
    logic          par_wr;
    logic          ser_step;
    logic          ser_take;
    logic          ser_to_af;
    logic [LW-1:0] ser_pos;
    logic          ctr_clr;

    assign par_wr   = (mode == PROG_PAR) && !ld_sel && !wr_en_n;
    assign ser_step = (mode == PROG_SER) && !ser_en_n;
    assign ctr_clr  = !mst_rst_n || !part_rst_n;

    ofs_serial_ctr #(.DW(DW)) u_ser (
        .clk     (wr_clk),
        .clr     (ctr_clr),
        .step    (ser_step),
        .take    (ser_take),
        .to_af   (ser_to_af),
        .bit_pos (ser_pos)
    );

    // Record that a master reset has happened (guards the assertions).
    always_ff @(posedge wr_clk) begin
        if (!mst_rst_n) had_mrst <= 1'b1;
    end

    // Method latch, preset load, parallel and serial updates.
    always_ff @(posedge wr_clk) begin
        if (!mst_rst_n) begin
            mode   <= prog_mode_e'(ld_sel);
            ae_off <= DW'(preset_ae(d_in[2:0]));
            af_off <= DW'(preset_af(d_in[2:0]));
            wptr   <= 1'b0;
        end else if (!part_rst_n) begin
            wptr   <= 1'b0;
        end else begin
            if (par_wr) begin
                if (!wptr) ae_off <= d_in;
                else       af_off <= d_in;
                wptr <= ~wptr;
            end
            if (ser_take) begin
                if (ser_to_af) af_off[ser_pos] <= ser_din;
                else           ae_off[ser_pos] <= ser_din;
            end
        end
    end

    // Partial reset keeps both offsets (R2).
    p_prst_keep_r2: assert property (@(posedge wr_clk)
        disable iff (!mst_rst_n || !had_mrst)
        !part_rst_n |=> ($stable(ae_off) && $stable(af_off)));
    // A parallel write lands in one of the two registers (R3).
    p_par_lands_r3: assert property (@(posedge wr_clk)
        disable iff (!mst_rst_n || !part_rst_n || !had_mrst)
        par_wr |=> (ae_off == $past(d_in) || af_off == $past(d_in)));
    // The method does not change outside master reset (R1).
    p_mode_hold_r1: assert property (@(posedge wr_clk)
        disable iff (!mst_rst_n || !had_mrst)
        1'b1 |=> $stable(mode));
    // Serial mode ignores parallel writes (R7).
    p_ser_no_par_r7: assert property (@(posedge wr_clk)
        disable iff (!mst_rst_n || !had_mrst)
        (mode == PROG_SER && ser_en_n) |=> ($stable(ae_off) && $stable(af_off)));

endmodule

// File: rtl/ofs_readback.sv
// Read-side threshold read-back. On a threshold read cycle in parallel mode it
// presents almost-empty then almost-full on alternate reads.
// Assumes the offsets are quasi-static while reads are made and both resets are
// synchronous to rd_clk.
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          rd_clk,
    input  logic          mst_rst_n,
    input  logic          part_rst_n,
    input  logic          ld_sel,
    input  logic          rd_en_n,
    input  prog_mode_e    mode,
    input  logic [DW-1:0] ae_off,
    input  logic [DW-1:0] af_off,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic rptr;        // 0: almost-empty next, 1: almost-full next
    logic ofs_rd;

    assign ofs_rd = (mode == PROG_PAR) && !ld_sel && !rd_en_n;

    // Output register and read order pointer.
    always_ff @(posedge rd_clk) begin
        if (!mst_rst_n || !part_rst_n) begin
            rptr     <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= ofs_rd;
            if (ofs_rd) begin
                rd_data <= rptr ? af_off : ae_off;
                rptr    <= ~rptr;
            end
        end
    end

    // Valid data only appears in parallel mode (R7).
    p_rb_par_only_r7: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !part_rst_n)
        rd_valid |-> (mode == PROG_PAR));
    // Consecutive reads alternate the register (R4).
    p_rb_alt_r4: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !part_rst_n)
        (ofs_rd && rd_valid) |=> (rptr != $past(rptr)));

endmodule

// File: rtl/ofs_prog_unit.sv
// Top of the threshold offset programming unit. It joins the write-side
// storage with the read-side read-back and decodes which enable cycles are
// FIFO data transfers rather than threshold accesses.
// Assumes resets are synchronous to both clocks and span an edge of each.
module ofs_prog_unit
    import ofs_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mst_rst_n,
    input  logic          part_rst_n,
    input  logic          ld_sel,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic          ser_en_n,
    input  logic          ser_din,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [DW-1:0] ae_off,
    output logic [DW-1:0] af_off,
    output logic          fifo_wr,
    output logic          fifo_rd
);
    prog_mode_e mode;
    logic       run;

    // Data transfers only outside reset and outside threshold access.
    assign run     = mst_rst_n && part_rst_n;
    assign fifo_wr = run && ld_sel && !wr_en_n;
    assign fifo_rd = run && ld_sel && !rd_en_n;

    ofs_store #(.DW(DW)) u_store (
        .wr_clk     (wr_clk),
        .mst_rst_n  (mst_rst_n),
        .part_rst_n (part_rst_n),
        .ld_sel     (ld_sel),
        .wr_en_n    (wr_en_n),
        .ser_en_n   (ser_en_n),
        .ser_din    (ser_din),
        .d_in       (d_in),
        .mode       (mode),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    ofs_readback #(.DW(DW)) u_rb (
        .rd_clk     (rd_clk),
        .mst_rst_n  (mst_rst_n),
        .part_rst_n (part_rst_n),
        .ld_sel     (ld_sel),
        .rd_en_n    (rd_en_n),
        .mode       (mode),
        .ae_off     (ae_off),
        .af_off     (af_off),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // A data write with no serial bit leaves the offsets alone (R9).
    p_fifo_wr_keep_r9: assert property (@(posedge wr_clk)
        disable iff (!mst_rst_n || !part_rst_n)
        (fifo_wr && ser_en_n) |=> ($stable(ae_off) && $stable(af_off)));
    // A data read never coincides with a threshold read-back (R9).
    p_fifo_rd_excl_r9: assert property (@(posedge rd_clk)
        disable iff (!mst_rst_n || !part_rst_n)
        fifo_rd |=> !rd_valid);

endmodule

// File: tb/sim_ofs_prog_unit.sv
module sim_ofs_prog_unit;
    localparam int DW = 18;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mst_rst_n = 1'b0;
    logic          part_rst_n = 1'b1;
    logic          ld_sel = 1'b1;
    logic          wr_en_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic          ser_en_n = 1'b1;
    logic          ser_din = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] rd_data, ae_off, af_off;
    logic          rd_valid, fifo_wr, fifo_rd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [DW-1:0] VAE [0:5] = '{18'h00000, 18'h3FFFF, 18'h15555,
                                           18'h2AAAA, 18'h00123, 18'h31F0E};
    localparam logic [DW-1:0] VAF [0:5] = '{18'h3FFFF, 18'h00000, 18'h2AAAA,
                                           18'h15555, 18'h3FEDC, 18'h00F31};

    ofs_prog_unit #(.DW(DW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst_n(mst_rst_n),
        .part_rst_n(part_rst_n), .ld_sel(ld_sel), .wr_en_n(wr_en_n),
        .rd_en_n(rd_en_n), .ser_en_n(ser_en_n), .ser_din(ser_din),
        .d_in(d_in), .rd_data(rd_data), .rd_valid(rd_valid),
        .ae_off(ae_off), .af_off(af_off), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd)
    );

    // 50 MHz write clock; read clock of the same rate, shifted by 2 ns.
    always #10 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #10 rd_clk = ~rd_clk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_sel = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1; ser_en_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge wr_clk); #5;
    endtask

    task automatic do_mrst(input logic ld, input logic [2:0] k);
        ld_sel = ld; d_in = DW'(k); mst_rst_n = 1'b0;
        tick(); tick();
        mst_rst_n = 1'b1; idle(); d_in = '0;
    endtask

    task automatic do_prst();
        part_rst_n = 1'b0;
        tick(); tick();
        part_rst_n = 1'b1;
    endtask

    task automatic wr_cyc(input logic ld, input logic [DW-1:0] d);
        ld_sel = ld; wr_en_n = 1'b0; d_in = d;
        tick(); idle();
    endtask

    task automatic rd_cyc();
        ld_sel = 1'b0; rd_en_n = 1'b0;
        tick(); idle();
    endtask

    task automatic ser_bit(input logic b);
        ser_en_n = 1'b0; ser_din = b;
        tick(); ser_en_n = 1'b1;
    endtask

    task automatic ser_word(input logic [DW-1:0] w);
        for (int i = 0; i < DW; i++) ser_bit(w[i]);
    endtask

    initial begin
        repeat (20000) @(posedge wr_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 / R10: reset state with preset index 3
        do_mrst(1'b0, 3'd3);
        check("R1 ae preset k=3", 32'(ae_off), 32'd63);
        check("R1 af preset k=3", 32'(af_off), 32'd127);
        check("R10 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R10 rd_data after reset", 32'(rd_data), 32'd0);
        check("R9 fifo_wr idle", 32'(fifo_wr), 32'd0);

        // R1: all eight presets
        for (int k = 0; k < 8; k++) begin
            do_mrst(1'b0, 3'(k));
            check("R1 ae preset", 32'(ae_off), (32'd8 << k) - 1);
            check("R1 af preset", 32'(af_off), (32'd16 << k) - 1);
        end

        // R3 / R4: vector table in parallel mode
        for (int v = 0; v < 6; v++) begin
            wr_cyc(1'b0, VAE[v]);
            wr_cyc(1'b0, VAF[v]);
            check("R3 ae written", 32'(ae_off), 32'(VAE[v]));
            check("R3 af written", 32'(af_off), 32'(VAF[v]));
            rd_cyc();
            check("R4 read ae valid", 32'(rd_valid), 32'd1);
            check("R4 read ae data", 32'(rd_data), 32'(VAE[v]));
            rd_cyc();
            check("R4 read af data", 32'(rd_data), 32'(VAF[v]));
            tick();
            check("R4 valid drops", 32'(rd_valid), 32'd0);
        end

        // R9: data transfer decode and no effect on offsets
        ld_sel = 1'b1; wr_en_n = 1'b0; #1;
        check("R9 fifo_wr data write", 32'(fifo_wr), 32'd1);
        ld_sel = 1'b0; #1;
        check("R9 fifo_wr on offset write", 32'(fifo_wr), 32'd0);
        idle(); ld_sel = 1'b1; rd_en_n = 1'b0; #1;
        check("R9 fifo_rd data read", 32'(fifo_rd), 32'd1);
        ld_sel = 1'b0; #1;
        check("R9 fifo_rd on offset read", 32'(fifo_rd), 32'd0);
        idle(); ld_sel = 1'b1; wr_en_n = 1'b0; part_rst_n = 1'b0; #1;
        check("R9 fifo_wr in partial reset", 32'(fifo_wr), 32'd0);
        part_rst_n = 1'b1; idle();
        tick();
        wr_cyc(1'b1, 18'h1ABCD);
        check("R9 ae after data write", 32'(ae_off), 32'(VAE[5]));
        check("R9 af after data write", 32'(af_off), 32'(VAF[5]));

        // R8: serial pins ignored in parallel mode
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        check("R8 ae unchanged", 32'(ae_off), 32'(VAE[5]));
        check("R8 af unchanged", 32'(af_off), 32'(VAF[5]));

        // R2: partial reset restarts write and read order, keeps values
        wr_cyc(1'b0, 18'h11111);
        do_prst();
        check("R2 ae kept", 32'(ae_off), 32'h11111);
        check("R2 af kept", 32'(af_off), 32'(VAF[5]));
        wr_cyc(1'b0, 18'h22222);
        check("R2 write order restart", 32'(ae_off), 32'h22222);
        check("R2 af untouched", 32'(af_off), 32'(VAF[5]));
        rd_cyc();
        do_prst();
        check("R10 rd_valid partial reset", 32'(rd_valid), 32'd0);
        rd_cyc();
        check("R2 read order restart", 32'(rd_data), 32'h22222);

        // R10: master reset clears read-back output
        check("R10 precondition", 32'(rd_data != 0), 32'd1);
        do_mrst(1'b1, 3'd0);
        check("R10 rd_data master reset", 32'(rd_data), 32'd0);
        check("R1 serial ae preset", 32'(ae_off), 32'd7);
        check("R1 serial af preset", 32'(af_off), 32'd15);

        // R5: serial loading, almost-empty first
        ser_word(18'h2A5C3);
        check("R5 ae serial", 32'(ae_off), 32'h2A5C3);
        check("R5 af still preset", 32'(af_off), 32'd15);
        ser_word(18'h13C5A);
        check("R5 af serial", 32'(af_off), 32'h13C5A);
        // R6: extra bits ignored
        for (int i = 0; i < 8; i++) ser_bit(1'b1);
        check("R6 ae after overrun", 32'(ae_off), 32'h2A5C3);
        check("R6 af after overrun", 32'(af_off), 32'h13C5A);
        // R7: parallel accesses ignored in serial mode
        wr_cyc(1'b0, 18'h3FFFF);
        wr_cyc(1'b0, 18'h3FFFF);
        check("R7 ae unchanged", 32'(ae_off), 32'h2A5C3);
        check("R7 af unchanged", 32'(af_off), 32'h13C5A);
        rd_cyc();
        check("R7 no read-back", 32'(rd_valid), 32'd0);
        // R2: partial reset restarts serial position
        do_prst();
        ser_word(18'h00F0F);
        check("R2 serial restart ae", 32'(ae_off), 32'h00F0F);
        check("R2 serial restart af kept", 32'(af_off), 32'h13C5A);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule